// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of an SDRAM device through its mandatory bring-up sequence each time reset is released. It raises the clock enable first and waits for a stabilization interval. It then closes all banks with a precharge-all command and issues a fixed train of auto-refresh commands. Last, it programs the device's mode register with a word composed from parameters. Every spacing between commands is enforced by a down-counter loaded from a timing parameter, and every cycle that carries no sequence command carries a NOP.

When the mode-register recovery time has elapsed, the block raises `init_done` and keeps it high until the next reset. Normal-operation logic then takes over the device. The finite-state machine has these states: `ST_IDLE` (held in reset, clock enable low), `ST_STABLE` (clock enable high, stabilization count), `ST_PRECHARGE`, `ST_PRE_GAP`, `ST_REFRESH`, `ST_REF_GAP`, `ST_LOAD_MODE`, `ST_MODE_GAP` and `ST_DONE`. Its transitions are:
- IDLE to STABLE on the first clock after reset release.
- STABLE to PRECHARGE when the stabilization count expires.
- PRECHARGE to PRE_GAP, then PRE_GAP to REFRESH when the precharge recovery expires.
- REFRESH to REF_GAP, then REF_GAP back to REFRESH while refreshes remain.
- REF_GAP to LOAD_MODE after the last refresh's recovery.
- LOAD_MODE to MODE_GAP, then MODE_GAP to DONE when the mode recovery expires.
- DONE holds until reset. An asserted reset returns any state to IDLE.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is low, the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111) and `init_done` is low.
- R2: `sd_cke` goes high on the first clock edge after reset release and stays high until the next reset.
- R3: A precharge-all command (0111 replaced by 0010) with address bit 10 high appears exactly `STABLE_CYCLES` cycles after `sd_cke` rises.
- R4: Exactly `REFRESH_COUNT` auto-refresh commands (0001) are issued. The first is `T_RP` cycles after the precharge, and each further one is `T_RFC` cycles after the previous one.
- R5: A load-mode command (0000) is issued `T_RFC` cycles after the last auto-refresh, with the mode word on `sd_addr` and zero on `sd_ba`.
- R6: Mode word layout: bits [2:0] burst code (0,1,2,3 for burst length 1,2,4,8), bit 3 burst type (1 = interleaved), bits [6:4] CAS latency, bits [8:7] zero, bit 9 set for single-location write bursts, all higher bits zero. The defaults give 0x230.
- R7: `init_done` rises exactly `T_MRD` cycles after the load-mode command and stays high until reset.
- R8: Every cycle that does not carry one of the commands above carries NOP, with `sd_addr` and `sd_ba` zero. No command is issued once `init_done` is high.
- R9: A reset asserted at any point in the sequence aborts it. After release, the whole sequence restarts from the clock-enable step with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, also the SDRAM command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus; carries A10 for precharge-all and the mode word for load-mode |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The checker watches several properties on every cycle:
- clock enable is low in reset and never drops until reset;
- only the four legal command codes ever appear;
- every command is followed by a NOP;
- precharge carries A10;
- the load-mode address equals the word composed from the mode parameters;
- `init_done` is sticky and silences the command bus.

The exact spacing of each command from its predecessor, the number of refreshes, and the cycle in which `init_done` rises are shown only by the bench's cycle-by-cycle comparison against a timeline it computes. That comparison also covers the restart after resets dropped at random or directed points in the sequence.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STABLE,
        ST_PRECHARGE,
        ST_PRE_GAP,
        ST_REFRESH,
        ST_REF_GAP,
        ST_LOAD_MODE,
        ST_MODE_GAP,
        ST_DONE
    } seq_state_e;

    // command codes on {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP       = 4'b0111;
    localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
    localparam logic [3:0] CMD_REFRESH   = 4'b0001;
    localparam logic [3:0] CMD_LOAD_MODE = 4'b0000;

    // address bit that selects all banks during precharge
    localparam int ALL_BANKS_BIT = 10;

    function automatic logic [2:0] burst_code(input int len);
        case (len)
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd0;
        endcase
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdinit_mode_word.sv
module sdinit_mode_word #(
    parameter int ADDR_W       = 13,
    parameter int BURST_LEN    = 1,
    parameter int INTERLEAVED  = 0,
    parameter int CAS_LAT      = 3,
    parameter int WRITE_SINGLE = 1
) (
    output logic [ADDR_W-1:0] word
);
    import sdinit_pkg::*;

    localparam logic [2:0] BL_CODE  = burst_code(BURST_LEN);
    localparam logic [2:0] CAS_CODE = 3'(CAS_LAT);

    always_comb begin
        word      = '0;
        word[2:0] = BL_CODE;
        word[3]   = (INTERLEAVED != 0);
        word[6:4] = CAS_CODE;
        word[8:7] = 2'b00;          // standard operating mode
        word[9]   = (WRITE_SINGLE != 0);
    end

endmodule

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdinit_cmd_drive.sv
module sdinit_cmd_drive #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  sdinit_pkg::seq_state_e state,
    input  logic [ADDR_W-1:0]      mode_word,
    output logic                   cke,
    output logic [3:0]             cmd,
    output logic [BA_W-1:0]        ba,
    output logic [ADDR_W-1:0]      addr
);
    import sdinit_pkg::*;

    always_comb begin
        cke  = 1'b1;
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_IDLE: begin
                cke = 1'b0;
            end
            ST_PRECHARGE: begin
                cmd                 = CMD_PRECHARGE;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            ST_REFRESH: begin
                cmd = CMD_REFRESH;
            end
            ST_LOAD_MODE: begin
                cmd  = CMD_LOAD_MODE;
                addr = mode_word;
            end
            ST_STABLE, ST_PRE_GAP, ST_REF_GAP, ST_MODE_GAP, ST_DONE: begin
                cmd = CMD_NOP;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int STABLE_CYCLES = 2_500_000,
    parameter int T_RP          = 2,
    parameter int T_RFC         = 6,
    parameter int T_MRD         = 2,
    parameter int REFRESH_COUNT = 8,
    parameter int BURST_LEN     = 1,
    parameter int INTERLEAVED   = 0,
    parameter int CAS_LAT       = 3,
    parameter int WRITE_SINGLE  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);
    import sdinit_pkg::*;

    localparam int CNT_W = $clog2(max4(STABLE_CYCLES, T_RP, T_RFC, T_MRD) + 1);
    localparam int REF_W = $clog2(REFRESH_COUNT + 1);

    // wait states last (gap - 1) cycles after their command; stabilization lasts its full count
    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(STABLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] LD_RFC    = CNT_W'(T_RFC - 2);
    localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 2);
    localparam logic [REF_W-1:0] REF_LAST  = REF_W'(REFRESH_COUNT);

    seq_state_e        state, state_nxt;
    logic [REF_W-1:0]  ref_cnt;
    logic              gap_load;
    logic [CNT_W-1:0]  gap_val;
    logic              gap_done;
    logic [ADDR_W-1:0] mode_word;
    logic [3:0]        cmd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ref_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE) begin
                ref_cnt <= '0;
            end else if (state == ST_REFRESH) begin
                ref_cnt <= ref_cnt + REF_W'(1);
            end
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      state_nxt = ST_STABLE;
            ST_STABLE:    if (gap_done) state_nxt = ST_PRECHARGE;
            ST_PRECHARGE: state_nxt = ST_PRE_GAP;
            ST_PRE_GAP:   if (gap_done) state_nxt = ST_REFRESH;
            ST_REFRESH:   state_nxt = ST_REF_GAP;
            ST_REF_GAP: begin
                if (gap_done) begin
                    state_nxt = (ref_cnt == REF_LAST) ? ST_LOAD_MODE : ST_REFRESH;
                end
            end
            ST_LOAD_MODE: state_nxt = ST_MODE_GAP;
            ST_MODE_GAP:  if (gap_done) state_nxt = ST_DONE;
            ST_DONE:      state_nxt = ST_DONE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // gap counter load selection
    always_comb begin
        gap_load = 1'b1;
        gap_val  = '0;
        unique case (state)
            ST_IDLE:      gap_val = LD_STABLE;
            ST_PRECHARGE: gap_val = LD_RP;
            ST_REFRESH:   gap_val = LD_RFC;
            ST_LOAD_MODE: gap_val = LD_MRD;
            default:      gap_load = 1'b0;
        endcase
    end

    sdinit_gap_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_done)
    );

    sdinit_mode_word #(
        .ADDR_W       (ADDR_W),
        .BURST_LEN    (BURST_LEN),
        .INTERLEAVED  (INTERLEAVED),
        .CAS_LAT      (CAS_LAT),
        .WRITE_SINGLE (WRITE_SINGLE)
    ) u_mode (
        .word (mode_word)
    );

    // outputs
    sdinit_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_drive (
        .state     (state),
        .mode_word (mode_word),
        .cke       (sd_cke),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign init_done = (state == ST_DONE);

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk #(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int BURST_LEN    = 1,
    parameter int INTERLEAVED  = 0,
    parameter int CAS_LAT      = 3,
    parameter int WRITE_SINGLE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    import sdinit_pkg::*;

    localparam int EXP_INT = $clog2(BURST_LEN) + 8 * INTERLEAVED + 16 * CAS_LAT + 512 * WRITE_SINGLE;
    localparam logic [ADDR_W-1:0] EXP_WORD = ADDR_W'(EXP_INT);

    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R1
    cke_low_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!sd_cke && !init_done && cmd == CMD_NOP));

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    // R8
    legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd == CMD_PRECHARGE || cmd == CMD_REFRESH || cmd == CMD_LOAD_MODE));

    // R8
    cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    // R3
    precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRECHARGE) |-> (sd_addr[ALL_BANKS_BIT] && sd_cke));

    // R4
    refresh_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFRESH) |-> (sd_cke && !init_done));

    // R6
    mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD_MODE) |-> (sd_addr == EXP_WORD && sd_ba == '0));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP && sd_cke));

endmodule

bind sdram_powerup_seq sdinit_chk #(
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W),
    .BURST_LEN    (BURST_LEN),
    .INTERLEAVED  (INTERLEAVED),
    .CAS_LAT      (CAS_LAT),
    .WRITE_SINGLE (WRITE_SINGLE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/test_sdram_powerup_seq.sv
`timescale 1ns/1ps
module test_sdram_powerup_seq;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int STABLE = 37;
    localparam int TRP    = 2;
    localparam int TRFC   = 6;
    localparam int TMRD   = 2;
    localparam int NREF   = 8;
    localparam int BL     = 1;
    localparam int INTL   = 0;
    localparam int CASL   = 3;
    localparam int WSING  = 1;
    localparam int SPAN   = 110;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] LMR = 4'b0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BA_W-1:0]   sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic              init_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sdram_powerup_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .STABLE_CYCLES(STABLE), .T_RP(TRP),
        .T_RFC(TRFC), .T_MRD(TMRD), .REFRESH_COUNT(NREF), .BURST_LEN(BL),
        .INTERLEAVED(INTL), .CAS_LAT(CASL), .WRITE_SINGLE(WSING)
    ) i_sdram_powerup_seq (
        .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
    );

    // timeline, k = clock edges since reset release
    localparam int K_PRE = 1 + STABLE;
    localparam int K_REF = K_PRE + TRP;
    localparam int K_LMR = K_REF + NREF * TRFC;
    localparam int K_DONE = K_LMR + TMRD;

    function automatic logic [ADDR_W-1:0] exp_mode();
        int bc;
        bc = (BL == 8) ? 3 : (BL == 4) ? 2 : (BL == 2) ? 1 : 0;
        return ADDR_W'(bc | (INTL << 3) | (CASL << 4) | (WSING << 9));
    endfunction

    function automatic logic [3:0] exp_cmd(int k);
        if (k == K_PRE) return PRE;
        for (int i = 0; i < NREF; i++) if (k == K_REF + i * TRFC) return REF;
        if (k == K_LMR) return LMR;
        return NOP;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(int k);
        if (k == K_PRE) return ADDR_W'(1 << 10);
        if (k == K_LMR) return exp_mode();
        return '0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_reset_state();
        chk(sd_cke == 1'b0, "R1", "cke in reset", 32'(sd_cke), 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1", "cmd in reset",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(NOP));
        chk(init_done == 1'b0, "R1", "done in reset", 32'(init_done), 0);
    endtask

    task automatic do_reset(int hold);
        #1 rst_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check_reset_state();
        end
    endtask

    task automatic check_cycle(int k, bit restarted);
        logic [3:0] c, ec;
        string tag;
        c  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        ec = exp_cmd(k);
        tag = (ec == PRE) ? "R3" : (ec == REF) ? "R4" : (ec == LMR) ? "R5" : "R8";
        chk(c == ec, tag, "command", 32'(c), 32'(ec));
        chk(sd_addr == exp_addr(k), (ec == LMR) ? "R6" : tag, "address",
            32'(sd_addr), 32'(exp_addr(k)));
        chk(sd_ba == '0, tag, "bank", 32'(sd_ba), 0);
        chk(sd_cke == 1'b1, "R2", "cke after release", 32'(sd_cke), 1);
        chk(init_done == (k >= K_DONE), "R7", "init_done", 32'(init_done), 32'(k >= K_DONE));
        if (restarted && k == K_PRE)
            chk(c == PRE, "R9", "precharge after restart", 32'(c), 32'(PRE));
    endtask

    // release reset at a negedge and follow; abort_at > 0 re-asserts reset at that cycle
    task automatic follow(int abort_at, bit restarted);
        rst_n = 1'b1;
        for (int k = 1; k <= SPAN; k++) begin
            @(negedge clk);
            if (k == abort_at) begin
                rst_n = 1'b0;
                #1;
                check_reset_state();   // R9 abort takes effect at once
                return;
            end
            check_cycle(k, restarted);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        do_reset(2 + int'($urandom % 8));
        follow(0, 1'b0);

        // mid-sequence resets: random points plus directed ones (first cycle, during refresh, after done)
        for (int n = 0; n < 5; n++) begin
            int ab;
            case (n)
                0: ab = 1;
                1: ab = K_REF + 3 * TRFC;
                2: ab = K_DONE + 5;
                default: ab = 2 + int'($urandom % (K_DONE - 2));
            endcase
            do_reset(1 + int'($urandom % 6));
            follow(ab, 1'b1);
            do_reset(1 + int'($urandom % 6));
            follow(0, 1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule